// File: doc/BRIEF.md
# One-shot OTG timeout timer

A single 32-bit control word arms a one-shot countdown, counted in device-clock ticks. The top bit of the word is the arm flag and the low 27 bits are the number of ticks to wait. The count advances only when the `tick` enable is high. `tick` is expected to strobe once per 60 MHz device-clock period, and it is produced in the same clock domain as the block.

When the countdown runs out, the block does two things in the same cycle. It wipes the stored word to zero and it raises a one-cycle `timeout` pulse. The interrupt logic latches that pulse into bit 16 of its source word.

Software restarts a running countdown by writing the word again with the arm flag set. It cancels the countdown by writing the word with the arm flag clear. Reads return whatever was last written, until the countdown expires.

Top module: `otg_oneshot_timer`

## Requirements
- R1: After reset, `rd_data` is 0 and `timeout` is 0. Without a later write, no tick ever produces a timeout.
- R2: A write stores all 32 bits of `wr_data`, and they appear on `rd_data` from the next cycle. `rd_data` then holds that value until the next write or an expiry.
- R3: A write with bit 31 set and a count N ≥ 1 in bits 26:0 arms the timer. The expiry happens on the clock edge of the Nth later cycle that has `tick` high. Cycles with `tick` low are not counted.
- R4: A write with bit 31 set and a count of 0 expires on the first later cycle that has `tick` high.
- R5: From the cycle in which `timeout` is high, `rd_data` reads 0.
- R6: `timeout` is high for exactly one cycle per expiry. Each arming produces at most one pulse, and further ticks after an expiry produce none.
- R7: A write with bit 31 set while a countdown runs discards the remaining count. Counting restarts from the newly written count.
- R8: A write with bit 31 clear cancels a pending expiry, so no timeout follows. The written value stays readable.
- R9: Bits 30:27 do not affect counting. They are only stored and read back.
- R10: When a write and a tick fall in the same cycle, the write wins. That tick is not counted against either the old count or the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: bit 31 arm flag, bits 26:0 tick count |
| tick | input | 1 | One-cycle device-clock tick enable |
| rd_data | output | 32 | Current control word, zero after expiry |
| timeout | output | 1 | One-cycle expiry pulse toward the interrupt source |

## Verification
A wrong remaining count shows up as a `timeout` pulse one or more ticks early or late. The reference model catches this on the exact edge where it happens. A stale arm flag shows up as a second pulse after an expiry, or as a pulse after a cancelling write. That surfaces on the first tick that follows. A missed wipe of the word is visible on `rd_data` in the same cycle as the pulse, because `rd_data` is compared against the model on every clock.

// File: rtl/otg_oneshot_timer.sv
module otg_oneshot_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 27,
  parameter int ARM_POS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic [DATA_W-1:0] rd_data,
  output logic              timeout
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  left_q;
  logic              armed_q;
  logic              fire_q;

  wire last_tick = (left_q <= ONE);
  wire advance   = armed_q & tick & ~wr_en;
  wire expire    = advance & last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      left_q  <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= expire;
      if (wr_en) begin
        word_q  <= wr_data;
        armed_q <= wr_data[ARM_POS];
        left_q  <= wr_data[CNT_W-1:0];
      end else if (expire) begin
        word_q  <= '0;
        armed_q <= 1'b0;
      end else if (advance) begin
        left_q  <= left_q - ONE;
      end
    end
  end

  assign rd_data = word_q;
  assign timeout = fire_q;
endmodule

// File: rtl/otg_oneshot_timer_chk.sv
module otg_oneshot_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ARM_POS = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick,
  input logic [DATA_W-1:0] rd_data,
  input logic              timeout
);
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_data == $past(rd_data)) || timeout); // R2
  AST_WIPE_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> rd_data == '0); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout); // R6
  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[ARM_POS]) |=> !timeout); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tick) |=> !timeout); // R10
endmodule

bind otg_oneshot_timer otg_oneshot_timer_chk #(.DATA_W(DATA_W), .ARM_POS(ARM_POS)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .tick(tick), .rd_data(rd_data), .timeout(timeout)
);

// File: tb/otg_oneshot_timer_test.sv
module otg_oneshot_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [31:0] rd_data;
  logic        timeout;

  int checks = 0, errors = 0, fires = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  logic [31:0] m_word = '0;
  bit          m_armed = 1'b0, m_pulse = 1'b0;
  int          m_left = 0;

  always #5 clk = ~clk;

  otg_oneshot_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .rd_data(rd_data), .timeout(timeout)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %h exp %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [31:0] d, input bit t);
    wr_en = w; wr_data = d; tick = t;
    @(posedge clk);
    m_pulse = 1'b0;
    if (!rst_n) begin
      m_word = '0; m_armed = 1'b0; m_left = 0;
    end else if (w) begin
      m_word = d; m_armed = d[31];
      m_left = (d[26:0] == 0) ? 1 : int'(d[26:0]);
    end else if (m_armed && t) begin
      m_left--;
      if (m_left == 0) begin
        m_armed = 1'b0; m_word = '0; m_pulse = 1'b1;
      end
    end
    @(negedge clk);
    if (timeout) fires++;
    check(rd_data == m_word, cur_tag, "rd_data", rd_data, m_word);
    check(timeout == m_pulse, cur_tag, "timeout", {31'b0, timeout}, {31'b0, m_pulse});
  endtask

  task automatic idle(input int n, input int gap);
    for (int i = 0; i < n; i++) step(1'b0, '0, (gap == 0) || (i % gap == 0));
  endtask

  task automatic expect_fires(input string tag, input int exp);
    check(fires == exp, tag, "fire count", fires, exp);
    fires = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act hung exp done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_tag = "R1";
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    rst_n = 1'b1;
    idle(10, 0);
    expect_fires("R1", 0);

    cur_tag = "R3";
    step(1'b1, 32'h8000_0003, 1'b0);
    idle(2, 0);
    check(timeout == 1'b0, "R3", "early timeout", {31'b0, timeout}, 32'h0);
    idle(1, 0);
    check(timeout == 1'b1, "R3", "timeout on 3rd tick", {31'b0, timeout}, 32'h1);
    check(rd_data == 32'h0, "R5", "wiped word", rd_data, 32'h0);
    idle(5, 0);
    expect_fires("R6", 1);

    step(1'b1, 32'h8000_0005, 1'b0);
    idle(20, 3);
    expect_fires("R3", 1);

    cur_tag = "R4";
    step(1'b1, 32'h8000_0000, 1'b0);
    idle(2, 0);
    expect_fires("R4", 1);

    cur_tag = "R9";
    step(1'b1, 32'hF800_0002, 1'b0);
    check(rd_data == 32'hF800_0002, "R2", "readback", rd_data, 32'hF800_0002);
    idle(1, 0);
    check(rd_data == 32'hF800_0002, "R9", "still counting", rd_data, 32'hF800_0002);
    idle(1, 0);
    check(timeout == 1'b1, "R9", "timeout on 2nd tick", {31'b0, timeout}, 32'h1);
    idle(4, 0);
    expect_fires("R9", 1);

    cur_tag = "R7";
    step(1'b1, 32'h8000_000A, 1'b0);
    idle(4, 0);
    step(1'b1, 32'h8000_0002, 1'b0);
    idle(1, 0);
    check(timeout == 1'b0, "R7", "no fire from old count", {31'b0, timeout}, 32'h0);
    idle(10, 0);
    expect_fires("R7", 1);

    cur_tag = "R8";
    step(1'b1, 32'h8000_0005, 1'b0);
    idle(2, 0);
    step(1'b1, 32'h0000_0005, 1'b0);
    idle(20, 0);
    check(rd_data == 32'h0000_0005, "R8", "held word", rd_data, 32'h5);
    expect_fires("R8", 0);

    cur_tag = "R10";
    step(1'b1, 32'h8000_0002, 1'b1);
    idle(1, 0);
    check(timeout == 1'b0, "R10", "write-cycle tick counted", {31'b0, timeout}, 32'h0);
    idle(1, 0);
    check(timeout == 1'b1, "R10", "fire after 2 later ticks", {31'b0, timeout}, 32'h1);
    step(1'b1, 32'h8000_0000, 1'b1);
    step(1'b1, 32'h8000_0000, 1'b1);
    idle(3, 0);
    expect_fires("R10", 2);

    cur_tag = "R1";
    step(1'b1, 32'h8000_0003, 1'b0);
    rst_n = 1'b0;
    step(1'b0, '0, 1'b1);
    rst_n = 1'b1;
    check(rd_data == 32'h0, "R1", "reset word", rd_data, 32'h0);
    idle(10, 0);
    expect_fires("R1", 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule